// File: doc/BRIEF.md
# Big-Endian to Little-Endian Byte-Lane Bus Bridge

This block connects the external bus port of a CPU that numbers its bytes big-endian to a 32-bit little-endian local-bus slave. The CPU starts a single transfer with a one-clock request. The bridge then registers a slave address, the slave byte enables and the remapped write data. It pulses an active-low address strobe and keeps the transfer open until the slave signals ready. Only then does it hand read data and a done pulse back to the CPU.

Two port widths are supported, chosen per transfer. In 32-bit mode the four byte lanes are mirrored: the CPU byte for offset 0 sits on the top lane, and the slave expects that byte on its bottom lane. The CPU's write byte enables are reversed to match. On reads the CPU drives its enable pins high, so the bridge requests a full word. In 8-bit mode the CPU always moves its byte on its top lane. The bridge steers that byte to or from the slave lane chosen by the low two address bits.

A timeout counter ends a transfer that never receives ready. The transfer then completes with an error flag, so the CPU never hangs.

Top module: `be_lane_bridge`

## Requirements
- R1: In 32-bit mode a write places CPU byte lane k (cpu_wdata[8k+7:8k]) on slave lane 3-k, so cpu_wdata[31:24] (offset 0) appears on slave_wdata[7:0].
- R2: On a 32-bit write, slave_be_n[g] equals cpu_wbe_n[3-g]. Here cpu_wbe_n[3] is the active-low enable for offset 0 (cpu_wdata[31:24]) and cpu_wbe_n[0] is the enable for offset 3.
- R3: On a 32-bit read, slave_be_n is 4'b0000 whatever cpu_wbe_n holds, and cpu_rdata is slave_rdata with lane g moved to lane 3-g.
- R4: On an 8-bit write, cpu_wdata[31:24] is driven on slave lane cpu_addr[1:0] and every other slave lane is zero. slave_be_n has a single low bit at position cpu_addr[1:0].
- R5: On an 8-bit read, slave lane cpu_addr[1:0] is returned on cpu_rdata[31:24], cpu_rdata[23:0] is zero, and slave_be_n has a single low bit at position cpu_addr[1:0].
- R6: slave_addr carries cpu_addr[31:2] and slave_wr carries the request direction. Both are registered when the request is accepted and are held until the transfer completes.
- R7: slave_ads_n goes low for exactly one clock, in the cycle after an accepted request.
- R8: A transfer stays open until slave_rdy_n is sampled low, however late that is. cpu_done pulses high for one clock in the cycle after ready is sampled, with cpu_err low and cpu_rdata valid.
- R9: If slave_rdy_n is not sampled low within TIMEOUT_CYCLES clocks after the strobe cycle begins, the bridge asserts cpu_done together with cpu_err.
- R10: slave_rdy_n has no effect while no transfer is open, and a request made in the cycle after cpu_done is not accepted.
- R11: After reset slave_ads_n is high, slave_be_n is 4'b1111, and cpu_done and cpu_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | One-clock request that starts a transfer |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_port8 | input | 1 | 1 = 8-bit port mode, 0 = 32-bit port mode |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Big-endian write data (offset 0 in bits 31:24) |
| cpu_wbe_n | input | 4 | Active-low write enables, bit 3 for offset 0 |
| cpu_rdata | output | 32 | Big-endian read data, valid with cpu_done |
| cpu_done | output | 1 | One-clock completion pulse |
| cpu_err | output | 1 | Timeout flag, valid with cpu_done |
| slave_addr | output | 30 | Word address cpu_addr[31:2] |
| slave_wr | output | 1 | Slave transfer direction |
| slave_ads_n | output | 1 | Active-low address strobe |
| slave_be_n | output | 4 | Active-low little-endian byte enables |
| slave_wdata | output | 32 | Little-endian write data |
| slave_rdata | input | 32 | Little-endian read data |
| slave_rdy_n | input | 1 | Active-low slave ready |

## Verification
The embedded properties assume that cpu_req is a single-clock pulse and that cpu_port8, cpu_addr and the write fields are meaningful only in the cycle the request is sampled. They also assume that slave_rdy_n carries meaning only while a transfer is open, although R10 also probes it while idle. The stimulus raises cpu_req for one cycle at a time, presents slave_rdata together with the ready it answers, and releases ready right after completion. Ready delays range from zero clocks to past the timeout, and a request is deliberately placed in the recovery cycle.

// File: rtl/be_bridge_pkg.sv
package be_bridge_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_ADDR = 2'd1,
    XS_WAIT = 2'd2,
    XS_GAP  = 2'd3
  } xfer_state_e;
endpackage

// File: rtl/be_wr_lane_map.sv
module be_wr_lane_map #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              port8,
  input  logic              wr,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] be_wdata,
  input  logic [LANES-1:0]  be_wbe_n,
  output logic [DATA_W-1:0] le_wdata,
  output logic [LANES-1:0]  le_be_n
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // mirrored lane for wide ports, steered top byte for narrow ports
    assign le_wdata[g*8 +: 8] = port8
      ? ((ofs == OFS_W'(g)) ? be_wdata[DATA_W-8 +: 8] : 8'h00)
      : be_wdata[(LANES-1-g)*8 +: 8];
    assign le_be_n[g] = port8
      ? (ofs != OFS_W'(g))
      : (wr ? be_wbe_n[LANES-1-g] : 1'b0);
  end
endmodule

// File: rtl/be_rd_steer.sv
module be_rd_steer #(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic              port8,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] le_rdata,
  output logic [DATA_W-1:0] be_rdata
);
  logic [DATA_W-1:0] wide_rd;

  for (genvar g = 0; g < LANES; g++) begin : g_mirror
    assign wide_rd[(LANES-1-g)*8 +: 8] = le_rdata[g*8 +: 8];
  end

  always_comb begin
    if (port8) begin
      be_rdata = '0;
      be_rdata[DATA_W-8 +: 8] = le_rdata[ofs*8 +: 8];
    end else begin
      be_rdata = wide_rd;
    end
  end
endmodule

// File: rtl/be_xfer_ctrl.sv
module be_xfer_ctrl
  import be_bridge_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 64,
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic rdy_n,
  output logic accept,
  output logic capture,
  output logic busy,
  output logic ads_n,
  output logic done,
  output logic err
);
  xfer_state_e state;
  logic [CNT_W-1:0] wait_cnt;

  assign busy    = (state == XS_ADDR) || (state == XS_WAIT);
  assign accept  = (state == XS_IDLE) && req;
  assign capture = busy && !rdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= XS_IDLE;
      ads_n    <= 1'b1;
      done     <= 1'b0;
      err      <= 1'b0;
      wait_cnt <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state)
        XS_IDLE: begin
          if (req) begin
            state    <= XS_ADDR;
            ads_n    <= 1'b0;
            wait_cnt <= '0;
          end
        end
        XS_ADDR, XS_WAIT: begin
          ads_n <= 1'b1;
          if (!rdy_n) begin
            done  <= 1'b1;
            state <= XS_GAP;
          end else if (wait_cnt == CNT_W'(TIMEOUT_CYCLES - 1)) begin
            done  <= 1'b1;
            err   <= 1'b1;
            state <= XS_GAP;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
            state    <= XS_WAIT;
          end
        end
        XS_GAP: state <= XS_IDLE;
        default: state <= XS_IDLE;
      endcase
    end
  end

  // R7
  ads_one_clk_chk: assert property (@(posedge clk) disable iff (rst)
    !ads_n |=> ads_n);
  // R8
  done_after_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !rdy_n) |=> (done && !err));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  no_accept_in_gap_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> ads_n);
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
endmodule

// File: rtl/be_lane_bridge.sv
module be_lane_bridge #(
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int TIMEOUT_CYCLES = 64,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_req,
  input  logic                cpu_wr,
  input  logic                cpu_port8,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  input  logic [LANES-1:0]    cpu_wbe_n,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                cpu_done,
  output logic                cpu_err,
  output logic [ADDR_W-OFS_W-1:0] slave_addr,
  output logic                slave_wr,
  output logic                slave_ads_n,
  output logic [LANES-1:0]    slave_be_n,
  output logic [DATA_W-1:0]   slave_wdata,
  input  logic [DATA_W-1:0]   slave_rdata,
  input  logic                slave_rdy_n
);
  logic accept, capture, busy;
  logic port8_q;
  logic [OFS_W-1:0] ofs_q;
  logic [DATA_W-1:0] map_wdata, steer_rdata;
  logic [LANES-1:0]  map_be_n;

  be_xfer_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) ctrl_i (
    .clk(clk), .rst(rst), .req(cpu_req), .rdy_n(slave_rdy_n),
    .accept(accept), .capture(capture), .busy(busy),
    .ads_n(slave_ads_n), .done(cpu_done), .err(cpu_err)
  );

  be_wr_lane_map #(.DATA_W(DATA_W)) wmap_i (
    .port8(cpu_port8), .wr(cpu_wr), .ofs(cpu_addr[OFS_W-1:0]),
    .be_wdata(cpu_wdata), .be_wbe_n(cpu_wbe_n),
    .le_wdata(map_wdata), .le_be_n(map_be_n)
  );

  be_rd_steer #(.DATA_W(DATA_W)) rsteer_i (
    .port8(port8_q), .ofs(ofs_q), .le_rdata(slave_rdata),
    .be_rdata(steer_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      port8_q     <= 1'b0;
      ofs_q       <= '0;
      slave_addr  <= '0;
      slave_wr    <= 1'b0;
      slave_be_n  <= '1;
      slave_wdata <= '0;
      cpu_rdata   <= '0;
    end else begin
      if (accept) begin
        port8_q     <= cpu_port8;
        ofs_q       <= cpu_addr[OFS_W-1:0];
        slave_addr  <= cpu_addr[ADDR_W-1:OFS_W];
        slave_wr    <= cpu_wr;
        slave_be_n  <= map_be_n;
        slave_wdata <= map_wdata;
      end
      if (capture) cpu_rdata <= steer_rdata;
    end
  end

  // R4
  narrow_be_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!slave_ads_n && port8_q) |-> ($countones(~slave_be_n) == 1));
  // R3
  wide_read_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!slave_ads_n && !port8_q && !slave_wr) |-> (slave_be_n == '0));
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && slave_ads_n) |-> ($stable(slave_addr) && $stable(slave_be_n)));
  // R5
  narrow_rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_done && port8_q && !cpu_err) |-> (cpu_rdata[DATA_W-9:0] == '0));
endmodule

// File: tb/be_lane_bridge_tb_top.sv
module be_lane_bridge_tb_top;
  localparam int TO = 64;

  typedef struct packed {
    logic        port8;
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [3:0]  wbe_n;
    logic [31:0] srd;
    logic [3:0]  ebe;
    logic [31:0] eswd;
    logic [31:0] ecrd;
    logic [2:0]  dly;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b0,1'b1,32'h1000_0000,32'h1122_3344,4'b0000,32'h0,        4'b0000,32'h4433_2211,32'h0,        3'd2},
    '{1'b0,1'b1,32'h2000_0004,32'hAABB_CCDD,4'b0111,32'h0,        4'b1110,32'hDDCC_BBAA,32'h0,        3'd0},
    '{1'b0,1'b1,32'h3000_0008,32'h0102_0304,4'b1100,32'h0,        4'b0011,32'h0403_0201,32'h0,        3'd1},
    '{1'b0,1'b0,32'h0000_03C0,32'h0,        4'b1111,32'h8765_4321,4'b0000,32'h0,        32'h2143_6587,3'd3},
    '{1'b1,1'b1,32'h0000_03C0,32'h5A12_3456,4'b1111,32'h0,        4'b1110,32'h0000_005A,32'h0,        3'd0},
    '{1'b1,1'b1,32'h0000_03C3,32'hC3FF_FFFF,4'b1111,32'h0,        4'b0111,32'hC300_0000,32'h0,        3'd2},
    '{1'b1,1'b1,32'h0000_03C1,32'h7E00_0000,4'b1111,32'h0,        4'b1101,32'h0000_7E00,32'h0,        3'd1},
    '{1'b1,1'b0,32'h0000_03CE,32'h0,        4'b1111,32'h11A5_2233,4'b1011,32'h0,        32'hA500_0000,3'd1},
    '{1'b1,1'b0,32'h0000_03C4,32'h0,        4'b1111,32'hDEAD_BE3C,4'b1110,32'h0,        32'h3C00_0000,3'd0},
    '{1'b1,1'b0,32'h0000_03C5,32'h0,        4'b1111,32'h0000_9900,4'b1101,32'h0,        32'h9900_0000,3'd4},
    '{1'b1,1'b0,32'h0000_03DB,32'h0,        4'b1111,32'h7100_0000,4'b0111,32'h0,        32'h7100_0000,3'd2}
  };

  logic clk = 1'b0;
  logic rst;
  logic cpu_req, cpu_wr, cpu_port8;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata, slave_wdata, slave_rdata;
  logic [3:0]  cpu_wbe_n, slave_be_n;
  logic cpu_done, cpu_err, slave_wr, slave_ads_n, slave_rdy_n;
  logic [29:0] slave_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  be_lane_bridge #(.TIMEOUT_CYCLES(TO)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_port8(cpu_port8), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wbe_n(cpu_wbe_n), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
    .cpu_err(cpu_err), .slave_addr(slave_addr), .slave_wr(slave_wr),
    .slave_ads_n(slave_ads_n), .slave_be_n(slave_be_n),
    .slave_wdata(slave_wdata), .slave_rdata(slave_rdata),
    .slave_rdy_n(slave_rdy_n)
  );

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one transfer from a vector; starts and ends at a negedge
  task automatic run_vec(input vec_t v);
    cpu_req = 1'b1; cpu_wr = v.wr; cpu_port8 = v.port8;
    cpu_addr = v.addr; cpu_wdata = v.wdata; cpu_wbe_n = v.wbe_n;
    @(negedge clk);
    cpu_req = 1'b0; cpu_wdata = 32'hFFFF_FFFF; cpu_addr = 32'h0;
    chk(slave_ads_n == 1'b0, "R7 strobe low", {31'h0, slave_ads_n}, 32'h0);
    chk(slave_addr == v.addr[31:2], "R6 address", {2'b0, slave_addr}, {2'b0, v.addr[31:2]});
    chk(slave_wr == v.wr, "R6 direction", {31'h0, slave_wr}, {31'h0, v.wr});
    if (!v.port8 && v.wr) chk(slave_be_n == v.ebe, "R2 reversed enables", {28'h0, slave_be_n}, {28'h0, v.ebe});
    if (!v.port8 && !v.wr) chk(slave_be_n == v.ebe, "R3 full-word enables", {28'h0, slave_be_n}, {28'h0, v.ebe});
    if (v.port8 && v.wr) chk(slave_be_n == v.ebe, "R4 narrow write enable", {28'h0, slave_be_n}, {28'h0, v.ebe});
    if (v.port8 && !v.wr) chk(slave_be_n == v.ebe, "R5 narrow read enable", {28'h0, slave_be_n}, {28'h0, v.ebe});
    if (v.wr && !v.port8) chk(slave_wdata == v.eswd, "R1 lane exchange", slave_wdata, v.eswd);
    if (v.wr && v.port8) chk(slave_wdata == v.eswd, "R4 lane steer", slave_wdata, v.eswd);
    for (int i = 0; i < int'(v.dly); i++) begin
      @(negedge clk);
      chk(slave_ads_n == 1'b1, "R7 strobe released", {31'h0, slave_ads_n}, 32'h1);
      chk(cpu_done == 1'b0, "R8 held open", {31'h0, cpu_done}, 32'h0);
    end
    slave_rdy_n = 1'b0; slave_rdata = v.srd;
    @(negedge clk);
    slave_rdy_n = 1'b1; slave_rdata = 32'h0;
    chk(cpu_done && !cpu_err, "R8 done on ready", {30'h0, cpu_done, cpu_err}, 32'h2);
    if (!v.wr && !v.port8) chk(cpu_rdata == v.ecrd, "R3 read swap", cpu_rdata, v.ecrd);
    if (!v.wr && v.port8) chk(cpu_rdata == v.ecrd, "R5 read steer", cpu_rdata, v.ecrd);
    @(negedge clk);
    chk(cpu_done == 1'b0, "R8 done is a pulse", {31'h0, cpu_done}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cpu_req = 1'b0; cpu_wr = 1'b0; cpu_port8 = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; cpu_wbe_n = 4'hF;
    slave_rdata = '0; slave_rdy_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(slave_ads_n && slave_be_n == 4'hF && !cpu_done && !cpu_err, "R11 reset state",
        {26'h0, slave_ads_n, slave_be_n, cpu_done}, {26'h0, 1'b1, 4'hF, 1'b0});
    rst = 1'b0;
    @(negedge clk);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R10: ready while idle has no effect
    slave_rdy_n = 1'b0; slave_rdata = 32'hDEAD_0000;
    repeat (3) begin
      @(negedge clk);
      chk(!cpu_done && slave_ads_n, "R10 idle ready ignored",
          {30'h0, cpu_done, slave_ads_n}, 32'h1);
    end
    slave_rdy_n = 1'b1;
    @(negedge clk);

    // R9: no ready at all
    cpu_req = 1'b1; cpu_wr = 1'b0; cpu_port8 = 1'b1; cpu_addr = 32'h3C2;
    @(negedge clk);
    cpu_req = 1'b0;
    chk(slave_ads_n == 1'b0, "R7 strobe on timeout run", {31'h0, slave_ads_n}, 32'h0);
    repeat (TO - 1) @(negedge clk);
    chk(cpu_done == 1'b0, "R9 not ended early", {31'h0, cpu_done}, 32'h0);
    @(negedge clk);
    chk(cpu_done && cpu_err, "R9 timeout error", {30'h0, cpu_done, cpu_err}, 32'h3);
    // R10: request in the cycle after done is refused
    cpu_req = 1'b1; cpu_wr = 1'b1; cpu_port8 = 1'b0; cpu_addr = 32'h40;
    @(negedge clk);
    cpu_req = 1'b0;
    chk(slave_ads_n == 1'b1, "R10 request after done refused", {31'h0, slave_ads_n}, 32'h1);
    @(negedge clk);
    chk(slave_ads_n == 1'b1, "R10 still idle", {31'h0, slave_ads_n}, 32'h1);

    // bridge still works after timeout
    run_vec(VECS[7]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule